// File: doc/BRIEF.md
# Serial Channel Error Flags with Clear Trigger

This block keeps the sticky error flags of one serial channel: overrun, parity and, where the channel supports it, framing. The channel logic raises a one-cycle detect pulse when it sees an error. The matching flag then sets and stays set until software clears it or the block is reset.

Software reaches the block over a small 16-bit register bus with two locations. The first is a read-only status register that shows the flags. The second is a write-only clear-trigger register. Writing a 1 to one of its bits clears the matching flag. The trigger register stores nothing, so it always reads as zero. When a new error and its clear arrive in the same cycle, the error wins and the flag stays set.

Top module: `serr_flag_regs`

## Requirements
- R1: After reset all flags are 0. The status register reads 0x0000, and so does the trigger register.
- R2: A one-cycle pulse on `ovr_det`, `par_det` or `frm_det` sets the matching flag on the next clock edge. The flag stays set with no further pulses. In the status register the flags sit at overrun bit 0, parity bit 1 and framing bit 2. Bits 15 to 3 always read 0.
- R3: A write to the trigger register (`reg_sel`=1) clears a flag when `byte_en[0]`=1 and the matching data bit is 1. Bit 0 clears overrun, bit 1 clears parity and bit 2 clears framing. The flag reads 0 after that clock edge. A 0 in a data bit leaves the matching flag unchanged.
- R4: If a detect pulse and a clear of the same flag fall in the same cycle, the flag is 1 after the edge.
- R5: A read of the trigger register always returns 0x0000, whatever was written to it and whatever flags are set.
- R6: A clear takes effect only when the low byte lane is enabled. That covers both a full write (`byte_en`=2'b11) and a low-byte write (`byte_en`=2'b01). A write with `byte_en`=2'b10 clears nothing. Data bits 15 to 3 have no effect.
- R7: The status register is read-only. A write with `reg_sel`=0 leaves every flag unchanged.
- R8: With `HAS_FRAMING`=0 the framing flag always reads 0 and `frm_det` is ignored. A trigger write to bit 2 then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 status, 1 clear trigger |
| wr_en | input | 1 | Write strobe |
| byte_en | input | 2 | Byte lane enables (bit 0 low byte, bit 1 high byte) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| ovr_det | input | 1 | Overrun detect pulse |
| par_det | input | 1 | Parity error detect pulse |
| frm_det | input | 1 | Framing error detect pulse |
| err_flags | output | 3 | Current flags {framing, parity, overrun} |

## Verification
The bound checker tests on every cycle that:
- a detect pulse always yields a set flag, even against a simultaneous clear;
- a flag persists unless a qualified trigger write names it;
- a trigger write without a coincident error clears its flag;
- the trigger register reads zero;
- the framing flag stays zero on channels without framing.

Some behaviours only the directed scenarios can show: the bit-to-flag mapping seen through the status read, the byte-lane qualification, and the fact that a status write has no effect.

// File: rtl/serr_flag_regs.sv
module serr_flag_regs #(
  parameter int W           = 16,
  parameter bit HAS_FRAMING = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic         wr_en,
  input  logic [1:0]   byte_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         ovr_det,
  input  logic         par_det,
  input  logic         frm_det,
  output logic [2:0]   err_flags
);
  localparam int NF = 3;

  logic [NF-1:0] flags_q, det, clr;
  logic          trig_wr;
  logic          unused_bits;

  assign trig_wr = wr_en & reg_sel & byte_en[0];
  assign clr     = trig_wr ? wdata[NF-1:0] : '0;
  assign det     = {frm_det & HAS_FRAMING, par_det, ovr_det};

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= det | (flags_q & ~clr);
  end

  assign rdata       = reg_sel ? '0 : {{(W-NF){1'b0}}, flags_q};
  assign err_flags   = flags_q;
  assign unused_bits = ^{byte_en[1], wdata[W-1:NF]};
endmodule

module serr_flag_regs_chk #(
  parameter int W           = 16,
  parameter bit HAS_FRAMING = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_sel,
  input logic         wr_en,
  input logic [1:0]   byte_en,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic         ovr_det,
  input logic         par_det,
  input logic [2:0]   err_flags
);
  logic clr_ovr, clr_par;
  assign clr_ovr = wr_en & reg_sel & byte_en[0] & wdata[0];
  assign clr_par = wr_en & reg_sel & byte_en[0] & wdata[1];

  // R2
  ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_det |=> err_flags[0]);
  // R4
  par_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_det && clr_par) |=> err_flags[1]);
  // R3
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr && !ovr_det) |=> !err_flags[0]);
  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[0] && !clr_ovr) |=> err_flags[0]);
  // R7
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[1] && !clr_par) |=> err_flags[1]);
  // R5
  trig_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> rdata == '0);
  // R8
  no_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_FRAMING |-> !err_flags[2]);
endmodule

bind serr_flag_regs serr_flag_regs_chk #(.W(W), .HAS_FRAMING(HAS_FRAMING)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
  .byte_en(byte_en), .wdata(wdata), .rdata(rdata), .ovr_det(ovr_det),
  .par_det(par_det), .err_flags(err_flags));

// File: tb/serr_flag_regs_test.sv
module serr_flag_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, wr_en = 1'b0;
  logic [1:0]  byte_en = 2'b00;
  logic [15:0] wdata = '0;
  logic        ovr_det = 1'b0, par_det = 1'b0, frm_det = 1'b0;
  logic [15:0] rdata, rdata_nf;
  logic [2:0]  flags, flags_nf;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serr_flag_regs uut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .byte_en(byte_en), .wdata(wdata), .rdata(rdata), .ovr_det(ovr_det),
    .par_det(par_det), .frm_det(frm_det), .err_flags(flags));

  serr_flag_regs #(.HAS_FRAMING(1'b0)) uut_nf (.clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .wr_en(wr_en), .byte_en(byte_en), .wdata(wdata),
    .rdata(rdata_nf), .ovr_det(ovr_det), .par_det(par_det), .frm_det(frm_det),
    .err_flags(flags_nf));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cycle(input logic sel, input logic we, input logic [1:0] be,
                       input logic [15:0] d, input logic [2:0] det);
    @(negedge clk);
    reg_sel = sel; wr_en = we; byte_en = be; wdata = d;
    {frm_det, par_det, ovr_det} = det;
    @(negedge clk);
    reg_sel = 1'b0; wr_en = 1'b0; byte_en = 2'b00; wdata = '0;
    {frm_det, par_det, ovr_det} = 3'b000;
    #1;
  endtask

  task automatic trig_read(output logic [15:0] v);
    reg_sel = 1'b1; #1; v = rdata; reg_sel = 1'b0; #1;
  endtask

  task automatic clear_all();
    cycle(1'b1, 1'b1, 2'b11, 16'h0007, 3'b000);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 status", rdata, 16'h0000);
    trig_read(v);
    chk("R1 trigger", v, 16'h0000);
  endtask

  task automatic t_set();
    cycle(1'b0, 1'b0, 2'b00, '0, 3'b001);
    chk("R2 overrun bit0", rdata, 16'h0001);
    cycle(1'b0, 1'b0, 2'b00, '0, 3'b010);
    chk("R2 parity bit1", rdata, 16'h0003);
    cycle(1'b0, 1'b0, 2'b00, '0, 3'b100);
    chk("R2 framing bit2", rdata, 16'h0007);
    repeat (3) @(negedge clk);
    #1 chk("R2 sticky", rdata, 16'h0007);
  endtask

  task automatic t_clear();
    cycle(1'b1, 1'b1, 2'b11, 16'h0000, 3'b000);
    chk("R3 zero write", rdata, 16'h0007);
    cycle(1'b1, 1'b1, 2'b11, 16'h0001, 3'b000);
    chk("R3 clear overrun", rdata, 16'h0006);
    cycle(1'b1, 1'b1, 2'b01, 16'h0002, 3'b000);
    chk("R3 clear parity", rdata, 16'h0004);
    cycle(1'b1, 1'b1, 2'b11, 16'h0004, 3'b000);
    chk("R3 clear framing", rdata, 16'h0000);
  endtask

  task automatic t_collision();
    cycle(1'b0, 1'b0, 2'b00, '0, 3'b011);
    cycle(1'b1, 1'b1, 2'b11, 16'h0003, 3'b001);
    chk("R4 overrun wins, parity cleared", rdata, 16'h0001);
    clear_all();
  endtask

  task automatic t_trig_read();
    logic [15:0] v;
    cycle(1'b0, 1'b0, 2'b00, '0, 3'b111);
    cycle(1'b1, 1'b1, 2'b10, 16'hFFFF, 3'b000);
    trig_read(v);
    chk("R5 trigger reads zero", v, 16'h0000);
  endtask

  task automatic t_lanes();
    chk("R6 high-byte write no clear", rdata, 16'h0007);
    cycle(1'b1, 1'b1, 2'b11, 16'hFFF8, 3'b000);
    chk("R6 upper bits ignored", rdata, 16'h0007);
    cycle(1'b1, 1'b0, 2'b11, 16'h0007, 3'b000);
    chk("R6 no strobe no clear", rdata, 16'h0007);
  endtask

  task automatic t_status_ro();
    cycle(1'b0, 1'b1, 2'b11, 16'h0000, 3'b000);
    chk("R7 status write ignored", rdata, 16'h0007);
    clear_all();
    cycle(1'b0, 1'b1, 2'b11, 16'h0007, 3'b000);
    chk("R7 status write sets nothing", rdata, 16'h0000);
  endtask

  task automatic t_noframe();
    cycle(1'b0, 1'b0, 2'b00, '0, 3'b100);
    chk("R8 framing ignored", rdata_nf, 16'h0000);
    chk("R8 framing on full channel", rdata, 16'h0004);
    cycle(1'b0, 1'b0, 2'b00, '0, 3'b011);
    cycle(1'b1, 1'b1, 2'b11, 16'h0004, 3'b000);
    chk("R8 bit2 trigger no effect", rdata_nf, 16'h0003);
    chk("R8 framing cleared on full channel", rdata, 16'h0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_set();
    t_clear();
    t_collision();
    t_trig_read();
    t_lanes();
    t_status_ro();
    t_noframe();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog got=hung exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule